// File: doc/BRIEF.md
# Interleaved DMA Address Generator

This block produces the pair of byte addresses, one for the source side and one for the destination side, that a copy engine needs for a two-dimensional interleaved transfer. The shape of the transfer is kept in a small template table. Each table entry describes one chunk: a count of contiguous bytes, followed by a gap that is skipped before the next chunk starts. One frame is the first `frame_len` entries taken in order. The frame is played `frame_cnt` times.

Software writes the table one entry at a time. It then sets both start addresses, an increment flag and a scatter flag for each side, the frame length, the frame count and a transfer direction, and pulses `start`. The direction, the flags, the start addresses and both lengths are captured at the start pulse. From then on the block offers one address pair per beat on a valid/ready handshake. It pulses `done` once the last byte has been addressed.

Each side uses one of three addressing styles:
- fixed at its start address,
- contiguous, where gaps are ignored,
- gap-skipping, where each chunk's gap is added after that chunk.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are low.
- R2: A chunk of size S produces exactly S accepted beats. Within a chunk, every side whose increment flag is set advances by one byte per accepted beat. Frame entries are used in index order 0 to `frame_len`-1, and the frame is repeated `frame_cnt` times.
- R3: A side with increment=1 and scatter=1 adds the current entry's gap after the last byte of that entry's chunk. Each entry carries its own gap.
- R4: A side with increment=1 and scatter=0 is addressed contiguously, so all gaps count as zero for it.
- R5: A side with increment=0 presents its start address on every beat, whatever its scatter flag says.
- R6: Source and destination use their own start addresses and their own flags, and neither side affects the other.
- R7: While `out_valid` is high and `out_ready` is low, both addresses hold. The next pair appears only after the current one has been accepted (valid and ready high on the same rising edge).
- R8: A table entry of size 0 issues no beat. It spends one cycle with `out_valid` low, and its gap is still applied to a gap-skipping side.
- R9: `done` is high for exactly one cycle. It rises in the cycle after the final beat is accepted, plus one cycle for each size-0 entry that ends the last frame. `busy` is high from the cycle after an accepted start up to `done`, and it is low while `done` is high.
- R10: A start with `frame_cnt`=0 or `frame_len`=0 gives `done` in the next cycle, with no beat, and `busy` stays low.
- R11: `xfer_dir` is coded as follows: 0 memory to memory, 1 memory to device, 2 device to memory, 3 device to device, 4 none. Codes 0 to 3 are accepted. A start with a code of 4 or above is refused: `busy` stays low, and no beat or `done` follows.
- R12: A start pulse while `busy` is high is ignored, together with any new start addresses presented with it. The running transfer continues unchanged.
- R13: An `abort` pulse ends a running transfer. In the next cycle `busy` and `out_valid` are low, and `done` does not rise for that transfer.
- R14: Addresses wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Template table write strobe |
| cfg_idx | input | 3 | Table entry to write |
| cfg_size | input | 16 | Chunk size in bytes for the entry |
| cfg_gap | input | 16 | Gap in bytes following the chunk |
| src_base | input | 32 | Source start address |
| dst_base | input | 32 | Destination start address |
| src_inc | input | 1 | Source address increments |
| src_scat | input | 1 | Source applies the gaps |
| dst_inc | input | 1 | Destination address increments |
| dst_scat | input | 1 | Destination applies the gaps |
| frame_len | input | 4 | Table entries per frame (0 to 8) |
| frame_cnt | input | 16 | Number of frame repetitions |
| xfer_dir | input | 3 | Direction code (see R11) |
| start | input | 1 | Start pulse |
| abort | input | 1 | Synchronous abort pulse |
| busy | output | 1 | Transfer in progress |
| out_valid | output | 1 | Address pair valid |
| out_ready | input | 1 | Consumer accepts the pair |
| out_src | output | 32 | Source byte address |
| out_dst | output | 32 | Destination byte address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs every combination of increment and scatter flags on both sides over two frame templates. The templates include gaps that differ per entry and size-0 entries, one of them in the final slot of the frame. Each run is checked against an address list computed in the bench. A side that leaks gaps into contiguous mode, or that moves when it is fixed, gives a wrong address. A design that skips a size-0 entry without applying its gap gives a wrong address, and one that skips it with no idle cycle moves `done` off its expected cycle.

Random back-pressure exposes addresses that move while a pair is stalled. Further runs cover a template of only size-0 entries, an empty transfer, refused direction codes, a start arriving mid-transfer, an abort, and start addresses just below 2^32. A start that is not refused or ignored shows up as a wrong address sequence, and a lost or doubled `done` shows up at the completion check.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   typedef enum logic [2:0] {
      DIR_M2M  = 3'd0,
      DIR_M2D  = 3'd1,
      DIR_D2M  = 3'd2,
      DIR_D2D  = 3'd3,
      DIR_NONE = 3'd4
   } dir_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

   localparam int NUM_SIDES = 2;

endpackage

// File: rtl/ilv_tmpl_tbl.sv
module ilv_tmpl_tbl #(
   parameter int DEPTH = 8,
   parameter int SZ_W  = 16,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [SZ_W-1:0]  wr_size,
   input  logic [SZ_W-1:0]  wr_gap,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [SZ_W-1:0]  rd_size,
   output logic [SZ_W-1:0]  rd_gap
);

   logic [SZ_W-1:0] size_q [DEPTH];
   logic [SZ_W-1:0] gap_q  [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_q[e] <= '0;
            gap_q[e]  <= '0;
         end else if (wr_en && wr_idx == IDX_W'(e)) begin
            size_q[e] <= wr_size;
            gap_q[e]  <= wr_gap;
         end
      end
   end

   assign rd_size = size_q[rd_idx];
   assign rd_gap  = gap_q[rd_idx];

endmodule

// File: rtl/ilv_chunk_seq.sv
module ilv_chunk_seq
   import ilv_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int SZ_W  = 16,
   parameter int CNT_W = 16,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int LEN_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [2:0]       dir,
   input  logic [LEN_W-1:0] len,
   input  logic [CNT_W-1:0] cnt,
   input  logic [SZ_W-1:0]  ent_size,
   input  logic             out_ready,
   output logic [IDX_W-1:0] rd_idx,
   output logic             load,
   output logic             valid,
   output logic             step,
   output logic             jump,
   output logic             busy,
   output logic             done
);

   seq_state_e       st_q;
   logic [IDX_W-1:0] ci_q;
   logic [SZ_W-1:0]  bo_q;
   logic [CNT_W-1:0] fc_q;
   logic [CNT_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic             done_q;

   logic running, start_ok, empty, beat, skip, last_byte;
   logic chunk_end, last_chunk, last_frame;

   assign running    = (st_q == ST_RUN);
   assign start_ok   = !running && start && !abort && (dir < 3'(DIR_NONE));
   assign empty      = (len == '0) || (cnt == '0);
   assign valid      = running && (ent_size != '0);
   assign beat       = valid && out_ready && !abort;
   assign skip       = running && (ent_size == '0) && !abort;
   assign last_byte  = (bo_q == ent_size - SZ_W'(1));
   assign chunk_end  = skip || (beat && last_byte);
   assign last_chunk = (LEN_W'(ci_q) + LEN_W'(1)) == len_q;
   assign last_frame = (fc_q + CNT_W'(1)) == cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ci_q   <= '0;
         bo_q   <= '0;
         fc_q   <= '0;
         cnt_q  <= '0;
         len_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_ok) begin
            ci_q  <= '0;
            bo_q  <= '0;
            fc_q  <= '0;
            len_q <= len;
            cnt_q <= cnt;
            if (empty) done_q <= 1'b1;
            else       st_q   <= ST_RUN;
         end else if (running) begin
            if (abort) begin
               st_q <= ST_IDLE;
            end else begin
               if (beat) bo_q <= last_byte ? '0 : bo_q + SZ_W'(1);
               if (chunk_end) begin
                  if (last_chunk) begin
                     ci_q <= '0;
                     if (last_frame) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        fc_q <= fc_q + CNT_W'(1);
                     end
                  end else begin
                     ci_q <= ci_q + IDX_W'(1);
                  end
               end
            end
         end
      end
   end

   assign rd_idx = ci_q;
   assign load   = start_ok;
   assign step   = beat;
   assign jump   = chunk_end;
   assign busy   = running;
   assign done   = done_q;

endmodule

// File: rtl/ilv_addr_side.sv
module ilv_addr_side #(
   parameter int AW   = 32,
   parameter int SZ_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [AW-1:0]   base,
   input  logic            inc_in,
   input  logic            scat_in,
   input  logic            step,
   input  logic            jump,
   input  logic [SZ_W-1:0] gap,
   output logic [AW-1:0]   addr,
   output logic            inc_q
);

   logic          scat_q;
   logic [AW-1:0] stride;

   always_comb begin
      stride = '0;
      if (inc_q) begin
         if (step)           stride = AW'(1);
         if (jump && scat_q) stride = stride + AW'(gap);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         inc_q  <= 1'b0;
         scat_q <= 1'b0;
      end else if (load) begin
         addr   <= base;
         inc_q  <= inc_in;
         scat_q <= scat_in;
      end else begin
         addr   <= addr + stride;
      end
   end

endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
   import ilv_pkg::*;
#(
   parameter int AW    = 32,
   parameter int SZ_W  = 16,
   parameter int DEPTH = 8,
   parameter int CNT_W = 16,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int LEN_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [SZ_W-1:0]  cfg_size,
   input  logic [SZ_W-1:0]  cfg_gap,
   input  logic [AW-1:0]    src_base,
   input  logic [AW-1:0]    dst_base,
   input  logic             src_inc,
   input  logic             src_scat,
   input  logic             dst_inc,
   input  logic             dst_scat,
   input  logic [LEN_W-1:0] frame_len,
   input  logic [CNT_W-1:0] frame_cnt,
   input  logic [2:0]       xfer_dir,
   input  logic             start,
   input  logic             abort,
   output logic             busy,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [AW-1:0]    out_src,
   output logic [AW-1:0]    out_dst,
   output logic             done
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ilv_addr_gen: DEPTH must be at least 2");
   end
   if (SZ_W > AW) begin : g_bad_sz
      $error("ilv_addr_gen: SZ_W must not exceed AW");
   end
   if (IDX_W != $clog2(DEPTH) || LEN_W != $clog2(DEPTH + 1)) begin : g_bad_w
      $error("ilv_addr_gen: IDX_W/LEN_W must stay at their derived values");
   end

   logic [IDX_W-1:0] rd_idx;
   logic [SZ_W-1:0]  ent_size, ent_gap;
   logic             load, step, jump;

   logic [AW-1:0]        side_base [NUM_SIDES];
   logic [AW-1:0]        side_addr [NUM_SIDES];
   logic [NUM_SIDES-1:0] side_inc_in, side_scat_in, side_inc;

   assign side_base[0]    = src_base;
   assign side_base[1]    = dst_base;
   assign side_inc_in     = {dst_inc, src_inc};
   assign side_scat_in    = {dst_scat, src_scat};

   ilv_tmpl_tbl #(.DEPTH(DEPTH), .SZ_W(SZ_W), .IDX_W(IDX_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_idx  (cfg_idx),
      .wr_size (cfg_size),
      .wr_gap  (cfg_gap),
      .rd_idx  (rd_idx),
      .rd_size (ent_size),
      .rd_gap  (ent_gap)
   );

   ilv_chunk_seq #(.DEPTH(DEPTH), .SZ_W(SZ_W), .CNT_W(CNT_W),
                   .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .abort     (abort),
      .dir       (xfer_dir),
      .len       (frame_len),
      .cnt       (frame_cnt),
      .ent_size  (ent_size),
      .out_ready (out_ready),
      .rd_idx    (rd_idx),
      .load      (load),
      .valid     (out_valid),
      .step      (step),
      .jump      (jump),
      .busy      (busy),
      .done      (done)
   );

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      ilv_addr_side #(.AW(AW), .SZ_W(SZ_W)) u_side (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (load),
         .base    (side_base[s]),
         .inc_in  (side_inc_in[s]),
         .scat_in (side_scat_in[s]),
         .step    (step),
         .jump    (jump),
         .gap     (ent_gap),
         .addr    (side_addr[s]),
         .inc_q   (side_inc[s])
      );
   end

   assign out_src = side_addr[0];
   assign out_dst = side_addr[1];

endmodule

// File: rtl/ilv_addr_gen_chk.sv
module ilv_addr_gen_chk #(
   parameter int AW    = 32,
   parameter int CNT_W = 16,
   parameter int LEN_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             abort,
   input logic [2:0]       xfer_dir,
   input logic [LEN_W-1:0] frame_len,
   input logic [CNT_W-1:0] frame_cnt,
   input logic             busy,
   input logic             out_valid,
   input logic             out_ready,
   input logic [AW-1:0]    out_src,
   input logic [AW-1:0]    out_dst,
   input logic             done,
   input logic [1:0]       side_inc
);

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy) else $error("done while busy"); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R9

   AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy) else $error("valid outside a transfer"); // R9

   AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !abort |=>
         out_valid && $stable(out_src) && $stable(out_dst))
      else $error("pair changed while stalled"); // R7

   AST_FIXED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !side_inc[0] |=> !busy || $stable(out_src))
      else $error("fixed source moved"); // R5

   AST_FIXED_DST: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !side_inc[1] |=> !busy || $stable(out_dst))
      else $error("fixed destination moved"); // R5

   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && abort |=> !busy && !out_valid && !done)
      else $error("abort did not idle"); // R13

   AST_REFUSE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && xfer_dir >= 3'd4 |=> !busy && !done)
      else $error("refused direction started"); // R11

   AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && !abort && xfer_dir < 3'd4 &&
      (frame_len == '0 || frame_cnt == '0) |=> done && !busy)
      else $error("empty transfer not completed"); // R10

endmodule

bind ilv_addr_gen ilv_addr_gen_chk #(.AW(AW), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/test_ilv_addr_gen.sv
module test_ilv_addr_gen;

   localparam int CLK_PERIOD = 10;
   localparam int MAXE       = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [15:0] cfg_size = '0, cfg_gap = '0;
   logic [31:0] src_base = '0, dst_base = '0;
   logic        src_inc = 1'b0, src_scat = 1'b0, dst_inc = 1'b0, dst_scat = 1'b0;
   logic [3:0]  frame_len = '0;
   logic [15:0] frame_cnt = '0;
   logic [2:0]  xfer_dir = '0;
   logic        start = 1'b0, abort = 1'b0, out_ready = 1'b0;
   logic        busy, out_valid, done;
   logic [31:0] out_src, out_dst;

   int n_chk = 0, n_bad = 0;
   int tsz [8];
   int tgp [8];
   logic [31:0] exp_s [MAXE];
   logic [31:0] exp_d [MAXE];
   logic [15:0] lfsr = 16'hACE1;
   bit          hung = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ilv_addr_gen i_ilv_addr_gen (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr_ent(input int idx, input int sz, input int gp);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_size = 16'(sz); cfg_gap = 16'(gp);
      tsz[idx] = sz; tgp[idx] = gp;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Arithmetic model of the address sequence built from the requirements.
   task automatic build(input int cnt, input int len, input logic [31:0] sb,
                        input logic [31:0] db, input bit si, input bit ss,
                        input bit di, input bit ds, output int n, output int tz);
      logic [31:0] s = sb;
      logic [31:0] d = db;
      n = 0;
      for (int f = 0; f < cnt; f++)
         for (int c = 0; c < len; c++) begin
            for (int b = 0; b < tsz[c]; b++) begin
               exp_s[n] = s; exp_d[n] = d; n++;
               if (si) s = s + 1;
               if (di) d = d + 1;
            end
            if (si && ss) s = s + 32'(tgp[c]);
            if (di && ds) d = d + 32'(tgp[c]);
         end
      tz = 0;
      if (cnt == 0 || len == 0) tz = 0;
      else if (n == 0) tz = len * cnt;
      else for (int c = len - 1; c >= 0 && tsz[c] == 0; c--) tz++;
   endtask

   task automatic run(input int cnt, input int len, input logic [31:0] sb,
                      input logic [31:0] db, input bit si, input bit ss,
                      input bit di, input bit ds, input int dir, input int rmode,
                      input bit poke, input string tag);
      int n, tz, k, since, cyc, mism, busy_bad;
      bit fin, r, empty;
      build(cnt, len, sb, db, si, ss, di, ds, n, tz);
      empty = (cnt == 0 || len == 0);
      k = 0; since = 0; cyc = 0; mism = 0; busy_bad = 0; fin = 1'b0;
      @(negedge clk);
      src_base = sb; dst_base = db; src_inc = si; src_scat = ss;
      dst_inc = di; dst_scat = ds; frame_len = 4'(len); frame_cnt = 16'(cnt);
      xfer_dir = 3'(dir); start = 1'b1;
      while (!fin && cyc < 3000) begin
         @(negedge clk);
         start = 1'b0;
         cyc++; since++;
         if (done) begin
            fin = 1'b1;
         end else begin
            if (!busy && !empty) busy_bad++;
            if (out_valid) begin
               if (k >= n || out_src !== exp_s[k] || out_dst !== exp_d[k]) mism++;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = (rmode == 0) ? 1'b1 : lfsr[0];
            out_ready = r;
            if (out_valid && r) begin
               k++;
               if (k == n) since = 0;
            end
            if (poke && cyc == 3) begin
               start = 1'b1; src_base = 32'hDEAD_0000; dst_base = 32'h0BAD_0000;
            end
         end
      end
      chk(mism == 0, {tag, " R2 R3 R4 R5 R6 R7 address sequence"}, 32'(mism), 0);
      chk(k == n, {tag, " R2 beat count"}, 32'(k), 32'(n));
      chk(fin && since == tz + 1, {tag, " R8 R9 done cycle"}, 32'(since), 32'(tz + 1));
      chk(busy_bad == 0 && !busy, {tag, " R9 busy span"}, 32'(busy_bad), 0);
      @(negedge clk);
      chk(!done && !busy, {tag, " R9 single done"}, {30'd0, done, busy}, 0);
      out_ready = 1'b0;
   endtask

   task automatic load_pat(input int p);
      if (p == 0) begin
         wr_ent(0, 3, 5); wr_ent(1, 1, 0); wr_ent(2, 0, 7);
         wr_ent(3, 4, 2); wr_ent(4, 2, 9);
         for (int e = 5; e < 8; e++) wr_ent(e, 1, 1);
      end else if (p == 1) begin
         wr_ent(0, 2, 4); wr_ent(1, 0, 3); wr_ent(2, 1, 6); wr_ent(3, 3, 1);
         wr_ent(4, 1, 0); wr_ent(5, 2, 8); wr_ent(6, 0, 2); wr_ent(7, 0, 5);
      end else begin
         for (int e = 0; e < 8; e++) wr_ent(e, 0, e + 1);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      hung = 1'b1;
   end

   initial begin : main
      int runid;
      for (int e = 0; e < 8; e++) begin tsz[e] = 0; tgp[e] = 0; end
      #(CLK_PERIOD * 2 + 1);
      // R1: reset state
      chk(!busy && !out_valid && !done, "R1 reset outputs",
          {29'd0, busy, out_valid, done}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !out_valid && !done, "R1 after release",
          {29'd0, busy, out_valid, done}, 0);

      runid = 0;
      for (int p = 0; p < 2; p++) begin
         load_pat(p);
         for (int fl = 0; fl < 16; fl++) begin
            run(1 + fl % 3, (p == 0) ? 5 : 8,
                32'h1000 + 32'(runid * 64), 32'h8000_0000 + 32'(runid * 3),
                fl[0], fl[1], fl[2], fl[3], runid % 4, (fl[0] ^ p), 1'b0, "sweep");
            runid++;
         end
      end

      // R14: wrap at 2^32
      load_pat(0);
      run(2, 5, 32'hFFFF_FFF8, 32'hFFFF_FFFE, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1, 1'b0, "R14 wrap");

      // R12: start while busy is ignored
      run(3, 5, 32'h0000_4000, 32'h0000_9000, 1'b1, 1'b0, 1'b1, 1'b1, 2, 1, 1'b1, "R12 restart");

      // R10: empty transfers
      run(0, 5, 32'h10, 32'h20, 1'b1, 1'b1, 1'b1, 1'b1, 0, 0, 1'b0, "R10 count0");
      run(2, 0, 32'h10, 32'h20, 1'b1, 1'b1, 1'b1, 1'b1, 3, 0, 1'b0, "R10 len0");

      // R8: frames of only zero-size entries
      load_pat(2);
      run(2, 3, 32'h300, 32'h400, 1'b1, 1'b1, 1'b1, 1'b0, 1, 0, 1'b0, "R8 all empty");

      // R11: refused direction codes
      load_pat(0);
      for (int dv = 4; dv < 8; dv += 3) begin
         bit seen;
         @(negedge clk);
         frame_len = 4'd5; frame_cnt = 16'd1; xfer_dir = 3'(dv); start = 1'b1;
         out_ready = 1'b1;
         @(negedge clk);
         start = 1'b0;
         seen = busy | out_valid | done;
         for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            seen = seen | busy | out_valid | done;
         end
         chk(!seen, "R11 refused start", 32'(seen), 0);
         out_ready = 1'b0;
      end

      // R13: abort mid-transfer
      begin
         bit seen;
         @(negedge clk);
         src_base = 32'h500; dst_base = 32'h600; src_inc = 1'b1; dst_inc = 1'b1;
         frame_len = 4'd5; frame_cnt = 16'd3; xfer_dir = 3'd0; start = 1'b1;
         out_ready = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (3) @(negedge clk);
         abort = 1'b1;
         @(negedge clk);
         abort = 1'b0;
         chk(!busy && !out_valid && !done, "R13 abort idles",
             {29'd0, busy, out_valid, done}, 0);
         seen = 1'b0;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            seen = seen | done | busy;
         end
         chk(!seen, "R13 no done after abort", 32'(seen), 0);
         out_ready = 1'b0;
      end
      run(1, 5, 32'h700, 32'h800, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1, 1'b0, "R13 recovery");

      if (hung) chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      if (hung) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R9 actual=0x%08h expected=0x%08h", 1, 0);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule